// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This block drives a scan chain that is cut into equal segments, so that during shift only one segment is clocked at a time. Fewer flip-flops toggle on any one edge, which lowers average and peak shift power in the logic the chain feeds. Segments are visited in ascending order. Each one receives exactly as many gated clock pulses as it has flip-flops before the schedule moves on. The block has no effect on capture: whenever scan-enable is low, every segment clock runs together.

Several parallel chains share one schedule. Chain `c`, segment `s` sits at flat index `c*NUM_SEG + s` on the segment input and output buses. Scan-in of each chain is steered to the active segment only. Scan-out of each chain comes from the active segment's serial output. Each gated clock comes from a latch that is transparent while the test clock is low, followed by an AND with the clock. A `shift_start` pulse starts one full pass. `done` reports the end of the pass.

Top module: `scan_seg_ctrl`

## Requirements
- R1: After reset, with scan-enable high and no shift-start, no segment clock pulses and done stays low.
- R2: A shift-start sampled with scan-enable high starts a pass on the following edge. Segment 0 is clocked first. Each segment gets exactly SEG_LEN gated pulses, and segment s+1 is clocked only after segment s has had all of its pulses.
- R3: While scan-enable is high, at most one segment clock pulses on any edge. During a pass it is the scheduled segment.
- R4: On every chain, the segment input `seg_si[c*NUM_SEG+s]` equals `scan_in[c]` for the segment about to be clocked and is 0 for every other segment. After a pass, each segment holds the SEG_LEN scan-in bits it was given, with the first bit in its last stage.
- R5: `scan_out[c]` equals `seg_so[c*NUM_SEG+s]`, where s is the segment being clocked in the current shift cycle. A full pass therefore unloads segment 0 first, then the following segments in order.
- R6: `done` is high for exactly one cycle, in the cycle after the last gated pulse of the last segment. After that, no segment clock pulses until the next shift-start.
- R7: While scan-enable is low, every segment clock pulses on every edge, so all segments capture together. Scan-enable going low during a pass abandons the pass without raising done.
- R8: A shift-start that arrives during a pass has no effect on the pulse schedule or on when done rises.
- R9: A segment clock enable changes only while the test clock is low, so the gated clocks carry only whole clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High selects shift mode; low selects capture/functional clocking |
| shift_start | input | 1 | One-cycle request to begin a segment-by-segment pass |
| scan_in | input | NUM_CHAINS | Serial scan data, one bit per chain |
| seg_so | input | NUM_CHAINS*NUM_SEG | Serial output of each segment, index c*NUM_SEG+s |
| seg_gclk | output | NUM_SEG | Gated clock for each segment, shared by all chains |
| seg_si | output | NUM_CHAINS*NUM_SEG | Routed serial input of each segment, index c*NUM_SEG+s |
| scan_out | output | NUM_CHAINS | Serial output of each chain, taken from the active segment |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
Shift cycle j of a pass is counted from the clock edge that takes in `shift_start`. In that cycle the gated pulse for segment j/SEG_LEN lands on the next rising edge. The bench checks `scan_out`, `seg_si` and the pulse counts in the low phase just before that edge, because the select register and the transparent enable latch have both settled by then. The gated clock vector is read one nanosecond after each rising edge. `done` is due in the low phase right after the edge that carries the last of the NUM_SEG*SEG_LEN pulses, and the bench expects it to be low again one cycle later. A capture edge is checked in the low phase that follows it, against each segment's content and its pulse count.

// File: rtl/scan_seg_pkg.sv
`timescale 1ns/1ps
package scan_seg_pkg;

  typedef enum logic {
    SCH_IDLE  = 1'b0,
    SCH_SHIFT = 1'b1
  } sch_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_seg_sched.sv
`timescale 1ns/1ps
module scan_seg_sched
  import scan_seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned SEG_LEN = 8,
  localparam int unsigned SEG_W  = idx_width(NUM_SEG),
  localparam int unsigned CNT_W  = idx_width(SEG_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               shift_start,
  output logic [NUM_SEG-1:0] gate_req,
  output logic [SEG_W-1:0]   sel,
  output logic [CNT_W-1:0]   cnt,
  output logic               busy,
  output logic               done
);

  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(NUM_SEG - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEG_LEN - 1);

  sch_state_e       state_q, state_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!scan_en) begin
      state_d = SCH_IDLE;
    end else begin
      case (state_q)
        SCH_IDLE: begin
          if (shift_start) begin
            state_d = SCH_SHIFT;
            seg_d   = '0;
            cnt_d   = LAST_CNT;
          end
        end
        SCH_SHIFT: begin
          if (cnt_q == '0) begin
            if (seg_q == LAST_SEG) begin
              state_d = SCH_IDLE;
              done_d  = 1'b1;
            end else begin
              seg_d = seg_q + 1'b1;
              cnt_d = LAST_CNT;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = SCH_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      seg_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seg_q   <= seg_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // enable request for the edge that follows the current cycle
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_req
    assign gate_req[s] = !scan_en ||
                         ((state_q == SCH_SHIFT) && (seg_q == SEG_W'(s)));
  end

  assign sel  = seg_q;
  assign cnt  = cnt_q;
  assign busy = (state_q == SCH_SHIFT);
  assign done = done_q;

endmodule

// File: rtl/scan_seg_cgate.sv
`timescale 1ns/1ps
module scan_seg_cgate (
  input  logic clk,
  input  logic en_req,
  output logic en_lat,
  output logic gclk
);

  // transparent while the clock is low; holds through the high phase
  always_latch begin
    if (!clk) en_lat = en_req;
  end

  assign gclk = clk & en_lat;

endmodule

// File: rtl/scan_seg_route.sv
`timescale 1ns/1ps
module scan_seg_route
  import scan_seg_pkg::*;
#(
  parameter int unsigned NUM_SEG    = 4,
  parameter int unsigned NUM_CHAINS = 2,
  localparam int unsigned SEG_W     = idx_width(NUM_SEG),
  localparam int unsigned FLAT      = NUM_SEG * NUM_CHAINS
) (
  input  logic [NUM_SEG-1:0]    gate_en,
  input  logic [SEG_W-1:0]      sel,
  input  logic [NUM_CHAINS-1:0] scan_in,
  input  logic [FLAT-1:0]       seg_so,
  output logic [FLAT-1:0]       seg_si,
  output logic [NUM_CHAINS-1:0] scan_out
);

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    // steer scan-in only to the segment whose clock is enabled
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_in
      assign seg_si[c*NUM_SEG + s] = gate_en[s] & scan_in[c];
    end

    // bypass multiplexer toward the chain output
    always_comb begin
      scan_out[c] = 1'b0;
      for (int s = 0; s < NUM_SEG; s++) begin
        if (sel == SEG_W'(s)) scan_out[c] = seg_so[c*NUM_SEG + s];
      end
    end
  end

endmodule

// File: rtl/scan_seg_ctrl.sv
`timescale 1ns/1ps
module scan_seg_ctrl
  import scan_seg_pkg::*;
#(
  parameter int unsigned NUM_SEG    = 4,
  parameter int unsigned SEG_LEN    = 8,
  parameter int unsigned NUM_CHAINS = 2,
  localparam int unsigned SEG_W     = idx_width(NUM_SEG),
  localparam int unsigned CNT_W     = idx_width(SEG_LEN),
  localparam int unsigned FLAT      = NUM_SEG * NUM_CHAINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  shift_start,
  input  logic [NUM_CHAINS-1:0] scan_in,
  input  logic [FLAT-1:0]       seg_so,
  output logic [NUM_SEG-1:0]    seg_gclk,
  output logic [FLAT-1:0]       seg_si,
  output logic [NUM_CHAINS-1:0] scan_out,
  output logic                  done
);

  // asynchronous assert, synchronous release
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic [NUM_SEG-1:0] gate_req;
  logic [NUM_SEG-1:0] gate_en;
  logic [SEG_W-1:0]   sel;
  logic [CNT_W-1:0]   cnt;
  logic               busy;

  scan_seg_sched #(
    .NUM_SEG (NUM_SEG),
    .SEG_LEN (SEG_LEN)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .scan_en     (scan_en),
    .shift_start (shift_start),
    .gate_req    (gate_req),
    .sel         (sel),
    .cnt         (cnt),
    .busy        (busy),
    .done        (done)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_gate
    scan_seg_cgate u_cg (
      .clk    (clk),
      .en_req (gate_req[s]),
      .en_lat (gate_en[s]),
      .gclk   (seg_gclk[s])
    );
  end

  scan_seg_route #(
    .NUM_SEG    (NUM_SEG),
    .NUM_CHAINS (NUM_CHAINS)
  ) u_route (
    .gate_en  (gate_en),
    .sel      (sel),
    .scan_in  (scan_in),
    .seg_so   (seg_so),
    .seg_si   (seg_si),
    .scan_out (scan_out)
  );

endmodule

// File: rtl/scan_seg_chk.sv
`timescale 1ns/1ps
module scan_seg_chk
  import scan_seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned SEG_LEN = 8,
  localparam int unsigned SEG_W  = idx_width(NUM_SEG),
  localparam int unsigned CNT_W  = idx_width(SEG_LEN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               done,
  input logic               busy,
  input logic [NUM_SEG-1:0] gate_en,
  input logic [SEG_W-1:0]   sel,
  input logic [CNT_W-1:0]   cnt
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !busy) |-> (gate_en == '0));

  assert_seg_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((sel == $past(sel)) || (sel == $past(sel) + 1'b1)));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= CNT_W'(SEG_LEN - 1)));

  assert_single_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> $onehot0(gate_en));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));

  assert_capture_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (&gate_en));

  // R9: enables move only in the low phase of the clock
  always @(gate_en) begin
    if (rst_n) begin
      assert_gate_stable_R9: assert (clk == 1'b0);
    end
  end

endmodule

bind scan_seg_ctrl scan_seg_chk #(
  .NUM_SEG (NUM_SEG),
  .SEG_LEN (SEG_LEN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .scan_en (scan_en),
  .done    (done),
  .busy    (busy),
  .gate_en (gate_en),
  .sel     (sel),
  .cnt     (cnt)
);

// File: tb/scan_seg_ctrl_test.sv
`timescale 1ns/1ps
module scan_seg_ctrl_test;

  localparam int N    = 4;
  localparam int L    = 5;
  localparam int C    = 2;
  localparam int FLAT = N * C;
  localparam int TOT  = N * L;

  logic            clk;
  logic            rst_n;
  logic            scan_en;
  logic            shift_start;
  logic [C-1:0]    scan_in;
  logic [FLAT-1:0] seg_so;
  logic [N-1:0]    seg_gclk;
  logic [FLAT-1:0] seg_si;
  logic [C-1:0]    scan_out;
  logic            done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // capture pattern presented to the segment models when scan_en is low
  logic [L-1:0] cap_pat [C][N];

  logic [L-1:0] seg_img [C][N];
  int unsigned  pcnt [N];

  scan_seg_ctrl #(.NUM_SEG(N), .SEG_LEN(L), .NUM_CHAINS(C)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .shift_start (shift_start),
    .scan_in     (scan_in),
    .seg_so      (seg_so),
    .seg_gclk    (seg_gclk),
    .seg_si      (seg_si),
    .scan_out    (scan_out),
    .done        (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // segment models: plain shift registers on their own gated clocks
  for (genvar s = 0; s < N; s++) begin : g_seg
    int unsigned pc = 0;
    always @(posedge seg_gclk[s]) pc <= pc + 1;
    assign pcnt[s] = pc;
    for (genvar c = 0; c < C; c++) begin : g_ch
      logic [L-1:0] r = '0;
      always @(posedge seg_gclk[s]) begin
        if (scan_en) r <= {r[L-2:0], seg_si[c*N + s]};
        else         r <= cap_pat[c][s];
      end
      assign seg_img[c][s]  = r;
      assign seg_so[c*N + s] = r[L-1];
    end
  end

  function automatic logic si_bit(input int p, input int j, input int c);
    return logic'(((p * 7 + j * 3 + c * 5) ^ (j >> 2) ^ (p >> 1)) & 1);
  endfunction

  function automatic logic [L-1:0] cap_val(input int p, input int c, input int s);
    return L'((p * 13 + c * 9 + s * 6 + 5) ^ (p << 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // capture edge: every segment clocked once, loaded with the pattern
  task automatic do_capture(input int p);
    int unsigned base [N];
    @(negedge clk);
    scan_en = 1'b0;
    for (int c = 0; c < C; c++)
      for (int s = 0; s < N; s++) cap_pat[c][s] = cap_val(p, c, s);
    for (int s = 0; s < N; s++) base[s] = pcnt[s];
    @(negedge clk);
    #1;
    for (int s = 0; s < N; s++) begin
      chk(pcnt[s] - base[s] == 1, "R7 capture pulse", int'(pcnt[s] - base[s]), 1);
      for (int c = 0; c < C; c++)
        chk(seg_img[c][s] == cap_pat[c][s], "R7 capture data",
            int'(seg_img[c][s]), int'(cap_pat[c][s]));
    end
  endtask

  // one full pass; restart_at >= 0 repeats shift_start mid-pass (R8)
  task automatic do_pass(input int p, input int restart_at);
    int unsigned base [N];
    int k, i;
    logic [C-1:0] exp_so;
    logic [FLAT-1:0] exp_si;
    do_capture(p);
    @(negedge clk);
    scan_en = 1'b1;
    shift_start = 1'b1;
    for (int s = 0; s < N; s++) base[s] = pcnt[s];
    @(negedge clk);
    for (int j = 0; j < TOT; j++) begin
      k = j / L;
      i = j % L;
      shift_start = (j == restart_at);
      for (int c = 0; c < C; c++) scan_in[c] = si_bit(p, j, c);
      #1;
      for (int c = 0; c < C; c++) exp_so[c] = cap_pat[c][k][L-1-i];
      chk(scan_out == exp_so, "R5 scan_out", int'(scan_out), int'(exp_so));
      exp_si = '0;
      for (int c = 0; c < C; c++) exp_si[c*N + k] = scan_in[c];
      chk(seg_si == exp_si, "R4 segment input", int'(seg_si), int'(exp_si));
      for (int s = 0; s < N; s++) begin
        int e;
        e = (s < k) ? L : ((s == k) ? i : 0);
        chk(int'(pcnt[s] - base[s]) == e, "R2 pulse schedule", int'(pcnt[s] - base[s]), e);
      end
      chk(done == 1'b0, "R6 done early", int'(done), 0);
      @(posedge clk);
      #1;
      chk(seg_gclk == N'(1 << k), "R3 R9 single gated clock", int'(seg_gclk), 1 << k);
      @(negedge clk);
    end
    shift_start = 1'b0;
    #1;
    chk(done == 1'b1, "R6 done due", int'(done), 1);
    for (int s = 0; s < N; s++)
      chk(int'(pcnt[s] - base[s]) == L, "R2 pulses per segment", int'(pcnt[s] - base[s]), L);
    for (int c = 0; c < C; c++)
      for (int s = 0; s < N; s++) begin
        logic [L-1:0] e;
        for (int b = 0; b < L; b++) e[L-1-b] = si_bit(p, s * L + b, c);
        chk(seg_img[c][s] == e, "R4 loaded segment", int'(seg_img[c][s]), int'(e));
      end
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R6 done width", int'(done), 0);
    for (int s = 0; s < N; s++) base[s] = pcnt[s];
    repeat (3) @(negedge clk);
    #1;
    for (int s = 0; s < N; s++)
      chk(pcnt[s] == base[s], "R6 idle after done", int'(pcnt[s] - base[s]), 0);
  endtask

  // scan_en dropped during a pass: all segments pulse, pass abandoned
  task automatic do_abort(input int p, input int drop_at);
    int unsigned base [N];
    int unsigned mid [N];
    int k, i;
    do_capture(p);
    @(negedge clk);
    scan_en = 1'b1;
    shift_start = 1'b1;
    for (int s = 0; s < N; s++) base[s] = pcnt[s];
    @(negedge clk);
    shift_start = 1'b0;
    repeat (drop_at) @(negedge clk);
    k = drop_at / L;
    i = drop_at % L;
    scan_en = 1'b0;
    for (int s = 0; s < N; s++) mid[s] = pcnt[s];
    @(negedge clk);
    #1;
    for (int s = 0; s < N; s++) begin
      int e;
      e = ((s < k) ? L : ((s == k) ? i : 0)) + 1;
      chk(int'(pcnt[s] - base[s]) == e, "R7 abort pulses", int'(pcnt[s] - base[s]), e);
      chk(pcnt[s] - mid[s] == 1, "R7 all clocked", int'(pcnt[s] - mid[s]), 1);
    end
    scan_en = 1'b1;
    for (int s = 0; s < N; s++) mid[s] = pcnt[s];
    for (int t = 0; t < TOT + 2; t++) begin
      @(negedge clk);
      #1;
      chk(done == 1'b0, "R7 no done after abort", int'(done), 0);
    end
    for (int s = 0; s < N; s++)
      chk(pcnt[s] == mid[s], "R7 idle after abort", int'(pcnt[s] - mid[s]), 0);
  endtask

  initial begin
    int unsigned base [N];
    rst_n = 1'b0;
    scan_en = 1'b1;
    shift_start = 1'b0;
    scan_in = '0;
    for (int c = 0; c < C; c++)
      for (int s = 0; s < N; s++) cap_pat[c][s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < N; s++) base[s] = pcnt[s];
    repeat (6) @(negedge clk);
    #1;
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int s = 0; s < N; s++)
      chk(pcnt[s] == base[s], "R1 no pulses after reset", int'(pcnt[s] - base[s]), 0);
    for (int p = 0; p < 8; p++) do_pass(p, -1);
    do_pass(8, 7);      // R8: restart request in segment 1
    do_pass(9, TOT - 1); // R8: restart request in the final shift cycle
    for (int d = 0; d < TOT; d += 3) do_abort(10 + d, d);
    finish_run();
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule